// File: doc/BRIEF.md
# Mode-Switched Cartridge Bank Register

This block turns CPU write cycles aimed at the read-only program space of a cartridge into bank-select state. A 7-bit ROM bank number drives the upper address bits of the switchable 16 KiB ROM window. A 2-bit RAM bank number drives the upper address bits of the 8 KiB external RAM window. The ROM bank number is built from two write windows. A low window supplies the five low bits. A high window supplies a 2-bit field that a mode flag steers either into the top two ROM bank bits or into the RAM bank number. A third window sets the mode flag.

Two configuration inputs describe the cartridge. `cfg_rom_log2` gives the ROM bank count as a power of two, and `cfg_ram_banks` gives the number of 8 KiB RAM banks that are fitted. The block only updates its registers on writes and has no read path. Reads, and writes outside the program space, leave it untouched. The address decode uses the top three address bits. Bit 15 must be 0, and bits 14:13 then select the window: 00 has no effect, 01 is the low window, 10 is the high window and 11 is the mode window.

Top module: `cart_bank_reg`

## Requirements
- R1: While reset is asserted, and after it is released, `rom_bank` is 1, `ram_bank` is 0 and the mode flag is 0, so that high-window writes steer into the ROM bank.
- R2: A write to 0x2000–0x3FFF forms a candidate ROM bank from data bits 4:0 as bank bits 4:0 and the current bank bits 6:5 as bank bits 6:5.
- R3: After a low-window write, and after the wrap of R7, a resulting bank of 0 is replaced by 1.
- R4: A write to 0x6000–0x7FFF sets the mode flag to data bit 0, and nothing else writes it.
- R5: With the mode flag at 0, a write to 0x4000–0x5FFF forms a candidate ROM bank from data bits 1:0 as bank bits 6:5 and the current bank bits 4:0. No zero replacement is applied, and `ram_bank` is unchanged.
- R6: With the mode flag at 1, a write to 0x4000–0x5FFF loads `ram_bank` with data bits 1:0 only when that value is below `cfg_ram_banks`, and otherwise keeps it. `rom_bank` is unchanged.
- R7: When a candidate ROM bank is strictly greater than 2^`cfg_rom_log2`, it is reduced to candidate mod 2^`cfg_rom_log2` (its low `cfg_rom_log2` bits). A candidate equal to the count is kept as it is.
- R8: When `wr_en` is low, or when the address is in 0x0000–0x1FFF or 0x8000–0xFFFF, neither output changes.
- R9: A new bank value appears on the outputs at the clock edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | CPU write strobe, one write per cycle in which it is high |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| cfg_rom_log2 | input | 3 | log2 of the ROM bank count (1 to 7) |
| cfg_ram_banks | input | 3 | Number of fitted 8 KiB RAM banks (0 to 4) |
| rom_bank | output | 7 | Selected bank for the switchable ROM window |
| ram_bank | output | 2 | Selected bank for the external RAM window |

## Verification
Several properties are checked on every cycle. A low-window write never leaves bank 0 behind, and a ROM write never leaves the bank above the configured count. The RAM bank only ever moves to a value below the fitted bank count. Neither bank register nor the mode flag changes without a write decoded to its own window. Only the bench's scenarios can show that the exact bit fields land in the right places and that the equal-to-count case survives the wrap. They also show that the mode flag really steers the high field, and that ignored addresses and idle strobes leave the outputs alone. For this the bench sweeps every low and high field value across all seven ROM sizes and every RAM size, and runs a long mixed run against an arithmetic model.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_LOW  = 2'd1,
    WIN_HIGH = 2'd2,
    WIN_MODE = 2'd3
  } win_e;
endpackage

// File: rtl/cbr_reset_sync.sv
module cbr_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cbr_win_decode.sv
module cbr_win_decode
  import cbr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output win_e              win
);
  always_comb begin
    win = WIN_NONE;
    if (wr_en && !addr[ADDR_W-1]) begin
      unique case (addr[ADDR_W-2:ADDR_W-3])
        2'b01:   win = WIN_LOW;
        2'b10:   win = WIN_HIGH;
        2'b11:   win = WIN_MODE;
        default: win = WIN_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cbr_rom_unit.sv
module cbr_rom_unit #(
  parameter int LO_W   = 5,
  parameter int HI_W   = 2,
  parameter int DATA_W = 8,
  localparam int ROM_W = LO_W + HI_W,
  localparam int LOG_W = $clog2(ROM_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LOG_W-1:0]  cfg_log2,
  output logic [ROM_W-1:0]  bank_q
);
  logic [ROM_W-1:0] cand;
  logic [ROM_W-1:0] wrapped;
  logic [ROM_W-1:0] bank_d;
  logic [ROM_W:0]   limit;
  logic [ROM_W:0]   mask;
  logic             upd;

  assign limit = (ROM_W+1)'(1) << cfg_log2;
  assign mask  = limit - (ROM_W+1)'(1);

  always_comb begin
    upd  = 1'b0;
    cand = bank_q;
    if (lo_we) begin
      upd  = 1'b1;
      cand = {bank_q[ROM_W-1:LO_W], wdata[LO_W-1:0]};
    end else if (hi_we) begin
      upd  = 1'b1;
      cand = {wdata[HI_W-1:0], bank_q[LO_W-1:0]};
    end
    wrapped = ({1'b0, cand} > limit) ? (cand & mask[ROM_W-1:0]) : cand;
    if (lo_we && (wrapped == '0)) wrapped = ROM_W'(1);
    bank_d = upd ? wrapped : bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   bank_q <= ROM_W'(1);
    else if (upd) bank_q <= bank_d;
  end

  p_low_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_we |=> (bank_q != '0));

  p_wrap_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we || hi_we) |=> ({1'b0, bank_q} <= $past(limit)));

  p_rom_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_we || hi_we) |=> $stable(bank_q));
endmodule

// File: rtl/cbr_ram_unit.sv
module cbr_ram_unit #(
  parameter int RAM_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [RAM_W:0]    cfg_banks,
  output logic [RAM_W-1:0]  bank_q
);
  logic [RAM_W-1:0] sel;
  logic             fits;
  logic             load;
  logic [RAM_W-1:0] bank_d;

  assign sel  = wdata[RAM_W-1:0];
  assign fits = ({1'b0, sel} < cfg_banks);
  assign load = we && fits;

  always_comb begin
    bank_d = bank_q;
    if (load) bank_d = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank_q <= '0;
    else if (load) bank_q <= bank_d;
  end

  p_ram_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_q) |-> ({1'b0, bank_q} < $past(cfg_banks)));

  p_ram_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(bank_q));
endmodule

// File: rtl/cart_bank_reg.sv
module cart_bank_reg
  import cbr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LO_W   = 5,
  parameter int HI_W   = 2,
  parameter int RAM_W  = 2,
  localparam int ROM_W = LO_W + HI_W,
  localparam int LOG_W = $clog2(ROM_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LOG_W-1:0]  cfg_rom_log2,
  input  logic [RAM_W:0]    cfg_ram_banks,
  output logic [ROM_W-1:0]  rom_bank,
  output logic [RAM_W-1:0]  ram_bank
);
  logic rst_sync_n;
  win_e win;
  logic mode_q;
  logic mode_d;
  logic mode_we;
  logic lo_we;
  logic hi_rom_we;
  logic hi_ram_we;

  cbr_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cbr_win_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en (wr_en),
    .addr  (addr),
    .win   (win)
  );

  assign lo_we     = (win == WIN_LOW);
  assign mode_we   = (win == WIN_MODE);
  assign hi_rom_we = (win == WIN_HIGH) && !mode_q;
  assign hi_ram_we = (win == WIN_HIGH) &&  mode_q;

  always_comb begin
    mode_d = mode_q;
    if (mode_we) mode_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mode_q <= 1'b0;
    else if (mode_we) mode_q <= mode_d;
  end

  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mode_we |=> $stable(mode_q));

  cbr_rom_unit #(.LO_W(LO_W), .HI_W(HI_W), .DATA_W(DATA_W)) u_rom (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .lo_we    (lo_we),
    .hi_we    (hi_rom_we),
    .wdata    (wdata),
    .cfg_log2 (cfg_rom_log2),
    .bank_q   (rom_bank)
  );

  cbr_ram_unit #(.RAM_W(RAM_W), .DATA_W(DATA_W)) u_ram (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we        (hi_ram_we),
    .wdata     (wdata),
    .cfg_banks (cfg_ram_banks),
    .bank_q    (ram_bank)
  );
endmodule

// File: tb/cart_bank_reg_tb_top.sv
module cart_bank_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic [2:0]  cfg_rom_log2;
  logic [2:0]  cfg_ram_banks;
  logic [6:0]  rom_bank;
  logic [1:0]  ram_bank;

  int checks = 0;
  int fails  = 0;
  int exp_rom;
  int exp_ram;
  int exp_mode;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  cart_bank_reg dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .addr          (addr),
    .wdata         (wdata),
    .cfg_rom_log2  (cfg_rom_log2),
    .cfg_ram_banks (cfg_ram_banks),
    .rom_bank      (rom_bank),
    .ram_bank      (ram_bank)
  );

  function automatic int wrap(input int c, input int k);
    int cnt = 1 << k;
    if (c > cnt) return c % cnt;
    return c;
  endfunction

  task automatic model(input logic [15:0] a, input logic [7:0] d);
    int c;
    if (a[15]) return;
    case (a[14:13])
      2'b01: begin
        c = (exp_rom & 8'h60) | (d & 8'h1F);
        c = wrap(c, cfg_rom_log2);
        if (c == 0) c = 1;
        exp_rom = c;
      end
      2'b10: begin
        if (exp_mode == 0) begin
          c = ((d & 3) << 5) | (exp_rom & 8'h1F);
          exp_rom = wrap(c, cfg_rom_log2);
        end else if ((d & 3) < cfg_ram_banks) begin
          exp_ram = d & 3;
        end
      end
      2'b11: exp_mode = d & 1;
      default: ;
    endcase
  endtask

  task automatic check(input string tag);
    checks++;
    if (rom_bank !== exp_rom[6:0]) begin
      fails++;
      $display("FAIL %s rom_bank actual %0d expected %0d", tag, rom_bank, exp_rom);
    end
    checks++;
    if (ram_bank !== exp_ram[1:0]) begin
      fails++;
      $display("FAIL %s ram_bank actual %0d expected %0d", tag, ram_bank, exp_ram);
    end
  endtask

  // Inputs change at the falling edge; the design registers on the rising
  // edge (R9), so the result is sampled at the following falling edge.
  task automatic bus_op(input logic we, input logic [15:0] a,
                        input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (we) model(a, d);
    check(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    exp_rom = 1; exp_ram = 0; exp_mode = 0;
    check("R1 during reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    cfg_rom_log2 = 3'd7; cfg_ram_banks = 3'd4;
    exp_rom = 1; exp_ram = 0; exp_mode = 0;
    do_reset();

    // R1: mode 0 after reset, so the high field goes into the ROM bank
    bus_op(1'b1, 16'h4000, 8'h02, "R1 R5 reset mode");

    // Sweep: every ROM size, every high field, every low field
    for (int k = 1; k <= 7; k++) begin
      cfg_rom_log2 = k[2:0];
      bus_op(1'b1, 16'h6000, 8'h00, "R4 mode0");
      for (int h = 0; h < 4; h++) begin
        bus_op(1'b1, 16'h4000 | 16'(h * 16'h111), 8'(h | 8'hFC), "R5 R7 high field");
        for (int l = 0; l < 32; l++)
          bus_op(1'b1, 16'h2000 + 16'(l * 16'h0F7), 8'(l | 8'hE0), "R2 R3 R7 low field");
      end
    end

    // Sweep: RAM banking in mode 1 for every fitted size
    cfg_rom_log2 = 3'd7;
    bus_op(1'b1, 16'h2000, 8'h15, "R2 setup");
    bus_op(1'b1, 16'h7FFF, 8'h01, "R4 mode1");
    for (int r = 0; r <= 4; r++) begin
      cfg_ram_banks = r[2:0];
      for (int d = 0; d < 8; d++)
        bus_op(1'b1, 16'h5000, 8'(d | 8'h40), "R6 ram select");
    end
    bus_op(1'b1, 16'h6000, 8'h02, "R4 even data clears mode");
    bus_op(1'b1, 16'h4000, 8'h03, "R5 back to rom");

    // Ignored windows and idle strobe
    bus_op(1'b1, 16'h0000, 8'h0A, "R8 enable window");
    bus_op(1'b1, 16'h1FFF, 8'hFF, "R8 enable window");
    bus_op(1'b1, 16'h8000, 8'h1F, "R8 upper space");
    bus_op(1'b1, 16'hA123, 8'h01, "R8 upper space");
    bus_op(1'b0, 16'h2000, 8'h07, "R8 no strobe");
    bus_op(1'b0, 16'h6000, 8'h01, "R8 no strobe");

    // Equal-to-count boundary: count 16, candidate 16 kept, 17 wraps to 1
    cfg_rom_log2 = 3'd4;
    bus_op(1'b1, 16'h6000, 8'h00, "R4 mode0");
    bus_op(1'b1, 16'h4000, 8'h00, "R5 clear top");
    bus_op(1'b1, 16'h2000, 8'h10, "R7 equal kept");
    bus_op(1'b1, 16'h2000, 8'h11, "R7 above wraps");
    bus_op(1'b1, 16'h2000, 8'h00, "R3 zero to one");

    // Mixed pseudo-random run over the whole address space
    for (int n = 0; n < 3000; n++) begin
      string tag;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if ((n % 64) == 0) begin
        @(negedge clk);
        cfg_rom_log2  = 3'd1 + 3'(lfsr[26:24] % 7);
        cfg_ram_banks = 3'(lfsr[29:27] % 5);
      end
      if (lfsr[31] || !lfsr[3] && !lfsr[4]) tag = "R8 mixed ignored";
      else case (lfsr[30:29])
        2'b01:   tag = "R2 mixed low";
        2'b10:   tag = "R5 R6 mixed high";
        2'b11:   tag = "R4 mixed mode";
        default: tag = "R8 mixed enable window";
      endcase
      bus_op(lfsr[3] | lfsr[4], lfsr[31:16], lfsr[15:8], tag);
    end

    // Reset in the middle of operation
    bus_op(1'b1, 16'h7000, 8'h01, "R4 mode1 before reset");
    do_reset();
    bus_op(1'b1, 16'h4000, 8'h01, "R1 mode cleared by reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule